// File: doc/BRIEF.md
# Delayed DMA Start Scheduler

This block sits in front of a multi-channel DMA engine and decides when each channel may begin a transfer. A channel counts as runnable when software has set its enable bit and its peripheral is asserting a request. Starts are never immediate. As soon as any channel becomes runnable, one countdown shared by all channels is armed. When that countdown runs out, the block walks the channels in ascending index order, one per clock, and gives a single-cycle start pulse to each channel that is runnable in its slot. If any channel is still runnable when the walk ends, the countdown is armed again at once.

The block also holds the register state the engine needs. This is a global priority/enable word, an interrupt control word, one control word per channel and one base address per channel, all on a simple strobe-based register bus. The engine reports completion on a per-channel `done` input, and that input clears the channel's enable bit.

Top module: `dma_start_sched`

## Requirements
- R1: A channel is runnable only when bit 24 of its control word is 1 and its `req` bit is 1. If either one is missing, no start pulse is ever produced for that channel.
- R2: When no countdown is pending, no walk is in progress and some channel becomes runnable, the countdown is armed with 10. The start for channel k appears in the cycle that begins 10+k clock edges after the arming edge.
- R3: While the countdown is pending, further channels that become runnable do not restart it. They are served in the same walk.
- R4: If no channel is runnable while the countdown is pending, the pending state and the countdown are cleared. The next runnable channel arms a fresh full delay.
- R5: A walk visits channels 0 to 6 in ascending order, one per cycle. `start[k]` is a single-cycle pulse, given only if channel k is runnable in its slot.
- R6: If any channel is runnable on the last cycle of a walk, the countdown is re-armed on that edge. A channel that stays runnable is therefore started every 17 cycles.
- R7: After reset the global word reads 0x07654321, the interrupt control word reads 0, every channel control word and address reads 0, and `start` is 0.
- R8: A channel address write stores only bits 23:0. Reads and `ch_addr` show the masked value.
- R9: Writing a channel control word never produces a start directly. Runnability found after the write goes through the full countdown.
- R10: `done[k]` clears bit 24 of channel k's control word and keeps its other bits. If a control write to channel k happens in the same cycle, `done[k]` wins.
- R11: `reg_sel` selects the register: 0 = global priority/enable, 1 = interrupt control, 2 = channel control, 3 = channel address. Channel registers use `reg_chan`. `rd_data` returns the stored value of the selected register. Writes to a channel index of 7 change nothing and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_chan | input | 3 | Channel index for channel registers |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| req | input | 7 | Peripheral request per channel |
| done | input | 7 | Transfer completion per channel, clears enable |
| start | output | 7 | Single-cycle start pulse per channel |
| ch_addr | output | 168 | Masked 24-bit base address per channel, channel 0 in the low bits |

## Verification
The main sweep arms all 127 non-empty sets of requesting channels at once. It checks that every member starts exactly at its slot offset and that non-members stay silent, which separates ordering errors, off-by-one delays and missed channels. Staggered patterns show whether the countdown is restarted or left alone: a late request while pending, a request that drops and returns, and a control write against a held request. A request that is held without completion shows the re-arm period. Register patterns cover reset values, masking, the out-of-range index and a completion arriving in the same cycle as a write.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int unsigned NUM_CH_DEF  = 7;
  localparam int unsigned DELAY_DEF   = 10;
  localparam int unsigned EN_BIT_DEF  = 24;
  localparam int unsigned ADDR_W_DEF  = 24;
  localparam int unsigned DATA_W      = 32;
  localparam logic [DATA_W-1:0] PRIO_RESET = 32'h0765_4321;

  typedef enum logic [1:0] {
    SEL_PRIO = 2'd0,
    SEL_IRQ  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_ADDR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_sched_rst_sync.sv
module dma_sched_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/dma_sched_regs.sv
module dma_sched_regs
  import dma_sched_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned EN_BIT = EN_BIT_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               reg_sel,
  input  logic [CH_W-1:0]          reg_chan,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [NUM_CH-1:0]        done,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NUM_CH-1:0]        ch_en,
  output logic [NUM_CH*ADDR_W-1:0] ch_addr
);
  localparam int unsigned PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] prio_q, prio_d, irq_q, irq_d;
  logic              prio_ce, irq_ce;
  logic [NUM_CH*DATA_W-1:0] ctrl_flat;

  // global words: next state
  always_comb begin
    prio_ce = wr_en && (reg_sel == SEL_PRIO);
    irq_ce  = wr_en && (reg_sel == SEL_IRQ);
    prio_d  = wr_data;
    irq_d   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= PRIO_RESET;
      irq_q  <= '0;
    end else begin
      if (prio_ce) prio_q <= prio_d;
      if (irq_ce)  irq_q  <= irq_d;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DATA_W-1:0] c_q, c_d;
    logic              c_ce;
    logic [ADDR_W-1:0] a_q, a_d;
    logic              a_ce;
    logic              hit;

    always_comb begin
      hit  = wr_en && (reg_chan == CH_W'(i));
      c_d  = c_q;
      c_ce = 1'b0;
      if (hit && reg_sel == SEL_CTRL) begin
        c_d  = wr_data;
        c_ce = 1'b1;
      end
      if (done[i]) begin
        c_d[EN_BIT] = 1'b0;
        c_ce        = 1'b1;
      end
      a_ce = hit && (reg_sel == SEL_ADDR);
      a_d  = wr_data[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0;
        a_q <= '0;
      end else begin
        if (c_ce) c_q <= c_d;
        if (a_ce) a_q <= a_d;
      end
    end

    assign ctrl_flat[i*DATA_W +: DATA_W] = c_q;
    assign ch_addr[i*ADDR_W +: ADDR_W]   = a_q;
    assign ch_en[i]                      = c_q[EN_BIT];

    // R10
    done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done[i] |=> !c_q[EN_BIT]);
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (reg_sel)
      SEL_PRIO: rd_data = prio_q;
      SEL_IRQ:  rd_data = irq_q;
      SEL_CTRL: begin
        for (int k = 0; k < NUM_CH; k++)
          if (reg_chan == CH_W'(k)) rd_data = ctrl_flat[k*DATA_W +: DATA_W];
      end
      default: begin
        for (int k = 0; k < NUM_CH; k++)
          if (reg_chan == CH_W'(k)) rd_data = {{PAD_W{1'b0}}, ch_addr[k*ADDR_W +: ADDR_W]};
      end
    endcase
  end

  // R8
  addr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_ADDR) |-> (rd_data[DATA_W-1:ADDR_W] == '0));
endmodule

// File: rtl/dma_sched_timer.sv
module dma_sched_timer #(
  parameter int unsigned DELAY = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_run,
  input  logic sweep_busy,
  input  logic sweep_done,
  output logic fire,
  output logic pending
);
  localparam int unsigned CNT_W = $clog2(DELAY + 1);

  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             arm;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    fire   = 1'b0;
    arm    = any_run && ((!pend_q && !sweep_busy) || sweep_done);
    if (arm) begin
      pend_d = 1'b1;
      cnt_d  = CNT_W'(DELAY);
    end else if (pend_q && !any_run) begin
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (pend_q) begin
      if (cnt_q <= CNT_W'(1)) begin
        pend_d = 1'b0;
        cnt_d  = '0;
        fire   = 1'b1;
      end else begin
        cnt_d  = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pending = pend_q;

  // R2
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !sweep_busy && any_run) |=> (pend_q && cnt_q == CNT_W'(DELAY)));
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && any_run && cnt_q > CNT_W'(1)) |=> (pend_q && cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R4
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !any_run && !sweep_done) |=> (!pend_q && cnt_q == '0));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DELAY));
endmodule

// File: rtl/dma_sched_dispatch.sv
module dma_sched_dispatch #(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [NUM_CH-1:0] runnable,
  output logic [NUM_CH-1:0] start,
  output logic              busy,
  output logic              sweep_done
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

  logic            busy_q, busy_d;
  logic [CH_W-1:0] idx_q, idx_d;

  always_comb begin
    busy_d     = busy_q;
    idx_d      = idx_q;
    sweep_done = busy_q && (idx_q == LAST);
    if (fire) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (sweep_done) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d  = idx_q + CH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_start
    assign start[i] = busy_q && (idx_q == CH_W'(i)) && runnable[i];
  end

  assign busy = busy_q;

  // R5
  walk_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (busy_q && idx_q == '0));
  // R5
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !sweep_done) |=> (busy_q && idx_q == $past(idx_q) + CH_W'(1)));
  // R5
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start));
endmodule

// File: rtl/dma_start_sched.sv
module dma_start_sched
  import dma_sched_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned CH_W   = $clog2(NUM_CH),
  parameter int unsigned DELAY  = DELAY_DEF,
  parameter int unsigned EN_BIT = EN_BIT_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               reg_sel,
  input  logic [CH_W-1:0]          reg_chan,
  input  logic [31:0]              wr_data,
  output logic [31:0]              rd_data,
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH-1:0]        done,
  output logic [NUM_CH-1:0]        start,
  output logic [NUM_CH*ADDR_W-1:0] ch_addr
);
  logic              rst_n_s;
  logic [NUM_CH-1:0] ch_en, runnable;
  logic              any_run, fire, pending, sweep_busy, sweep_done;

  dma_sched_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  dma_sched_regs #(
    .NUM_CH (NUM_CH), .CH_W (CH_W), .EN_BIT (EN_BIT), .ADDR_W (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .reg_sel  (reg_sel),
    .reg_chan (reg_chan),
    .wr_data  (wr_data),
    .done     (done),
    .rd_data  (rd_data),
    .ch_en    (ch_en),
    .ch_addr  (ch_addr)
  );

  assign runnable = ch_en & req;
  assign any_run  = |runnable;

  dma_sched_timer #(.DELAY (DELAY)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .any_run    (any_run),
    .sweep_busy (sweep_busy),
    .sweep_done (sweep_done),
    .fire       (fire),
    .pending    (pending)
  );

  dma_sched_dispatch #(.NUM_CH (NUM_CH), .CH_W (CH_W)) u_disp (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .fire       (fire),
    .runnable   (runnable),
    .start      (start),
    .busy       (sweep_busy),
    .sweep_done (sweep_done)
  );

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(pending && sweep_busy));
  // R9
  write_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && reg_sel == SEL_CTRL && !pending && !sweep_busy) |=> (start == '0));
  // R1
  start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((start & ~req) == '0));
endmodule

// File: tb/dma_start_sched_test.sv
module dma_start_sched_test;
  localparam int NCH   = 7;
  localparam int DLY   = 10;
  localparam int AW    = 24;
  localparam logic [31:0] EN = 32'h0100_0000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [1:0]      reg_sel;
  logic [2:0]      reg_chan;
  logic [31:0]     wr_data;
  logic [31:0]     rd_data;
  logic [NCH-1:0]  req, done, start;
  logic [NCH*AW-1:0] ch_addr;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int got [NCH];
  int second [NCH];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_start_sched uut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .reg_sel (reg_sel),
    .reg_chan (reg_chan), .wr_data (wr_data), .rd_data (rd_data),
    .req (req), .done (done), .start (start), .ch_addr (ch_addr)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [2:0] c, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = s; reg_chan = c; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [2:0] c, output logic [31:0] v);
    reg_sel = s; reg_chan = c;
    #1;
    v = rd_data;
  endtask

  task automatic clear_got();
    for (int k = 0; k < NCH; k++) begin got[k] = -1; second[k] = -1; end
  endtask

  task automatic observe(input int n, input bit autodone);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      done = '0;
      for (int k = 0; k < NCH; k++) begin
        if (start[k]) begin
          if (got[k] < 0) got[k] = cyc;
          else if (second[k] < 0) second[k] = cyc;
          if (autodone) begin req[k] = 1'b0; done[k] = 1'b1; end
        end
      end
    end
    @(negedge clk);
    done = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] snap [NCH];
    int c0, arm, bad, bad_k, bad_act, bad_exp;
    rst_n = 1'b0; wr_en = 1'b0; reg_sel = '0; reg_chan = '0; wr_data = '0;
    req = '0; done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7 reset values
    rd(2'd0, 3'd0, v); check(v == 32'h0765_4321, "R7 global reset", v, 32'h0765_4321);
    rd(2'd1, 3'd0, v); check(v == 0, "R7 irq reset", v, 0);
    bad = 0;
    for (int k = 0; k < NCH; k++) begin
      rd(2'd2, 3'(k), v); if (v != 0) bad++;
      rd(2'd3, 3'(k), v); if (v != 0) bad++;
    end
    check(bad == 0 && start == 0, "R7 channel regs and start", bad, 0);

    // R11 global readback
    wr(2'd0, 3'd0, 32'h1234_5678); rd(2'd0, 3'd0, v);
    check(v == 32'h1234_5678, "R11 global readback", v, 32'h1234_5678);
    wr(2'd1, 3'd0, 32'hDEAD_BEEF); rd(2'd1, 3'd0, v);
    check(v == 32'hDEAD_BEEF, "R11 irq readback", v, 32'hDEAD_BEEF);

    // R8 address masking
    wr(2'd3, 3'd3, 32'hFFFF_FFFF); rd(2'd3, 3'd3, v);
    check(v == 32'h00FF_FFFF, "R8 addr read", v, 32'h00FF_FFFF);
    check(ch_addr[3*AW +: AW] == 24'hFF_FFFF, "R8 addr port", ch_addr[3*AW +: AW], 24'hFF_FFFF);
    wr(2'd3, 3'd0, 32'h1234_5678); rd(2'd3, 3'd0, v);
    check(v == 32'h0034_5678, "R8 addr low bits", v, 32'h0034_5678);

    // R10 done clears only the enable bit
    wr(2'd2, 3'd1, 32'h0100_00A5); rd(2'd2, 3'd1, v);
    check(v == 32'h0100_00A5, "R11 ctrl readback", v, 32'h0100_00A5);
    @(negedge clk); done = 7'b0000010; @(negedge clk); done = '0;
    rd(2'd2, 3'd1, v);
    check(v == 32'h0000_00A5, "R10 done clears enable", v, 32'h0000_00A5);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = 2'd2; reg_chan = 3'd2; wr_data = EN; done = 7'b0000100;
    @(negedge clk); wr_en = 1'b0; done = '0;
    rd(2'd2, 3'd2, v);
    check(v == 0, "R10 done beats write", v, 0);

    // R11 channel index 7 ignored
    for (int k = 0; k < NCH; k++) rd(2'd2, 3'(k), snap[k]);
    wr(2'd2, 3'd7, 32'hFFFF_FFFF);
    bad = 0;
    for (int k = 0; k < NCH; k++) begin rd(2'd2, 3'(k), v); if (v != snap[k]) bad++; end
    rd(2'd2, 3'd7, v);
    check(bad == 0 && v == 0, "R11 index 7 ignored", bad + int'(v != 0), 0);

    // R1 enable without request, request without enable
    wr(2'd2, 3'd0, EN);
    clear_got(); observe(25, 1);
    check(got[0] < 0, "R1 enable only", got[0], -1);
    @(negedge clk); req = 7'b1000000;
    clear_got(); observe(25, 1);
    check(got[6] < 0, "R1 request only", got[6], -1);
    @(negedge clk); req = '0; done = 7'b0000001; @(negedge clk); done = '0;

    // R2 R5: sweep all non-empty channel sets
    bad = 0; bad_k = 0; bad_act = 0; bad_exp = 0;
    for (int m = 1; m < (1 << NCH); m++) begin
      for (int k = 0; k < NCH; k++) wr(2'd2, 3'(k), EN);
      @(negedge clk);
      c0 = cyc; req = 7'(m); arm = c0 + 1;
      clear_got(); observe(30, 1);
      for (int k = 0; k < NCH; k++) begin
        int e;
        e = m[k] ? arm + DLY + k : -1;
        if ((got[k] != e || second[k] >= 0) && bad == 0) begin
          bad_k = k; bad_act = got[k]; bad_exp = e;
        end
        if (got[k] != e || second[k] >= 0) bad++;
      end
      check(bad == 0, $sformatf("R2 R5 set %0d channel %0d start cycle", m, bad_k), bad_act, bad_exp);
      if (bad != 0) break;
    end

    // R6 held request re-arms every 17 cycles
    wr(2'd2, 3'd2, EN);
    @(negedge clk); c0 = cyc; req = 7'b0000100; arm = c0 + 1;
    clear_got(); observe(45, 0);
    check(got[2] == arm + DLY + 2, "R6 first start", got[2], arm + DLY + 2);
    check(second[2] == got[2] + DLY + NCH, "R6 re-arm period", second[2] - got[2], DLY + NCH);
    req = '0; done = 7'b0000100; @(negedge clk); done = '0;
    observe(20, 1);

    // R3 late request does not restart the countdown
    wr(2'd2, 3'd1, EN); wr(2'd2, 3'd5, EN);
    @(negedge clk); c0 = cyc; req = 7'b0100000; arm = c0 + 1;
    clear_got(); observe(3, 1);
    req[1] = 1'b1;
    observe(20, 1);
    check(got[1] == arm + DLY + 1, "R3 late channel in same walk", got[1], arm + DLY + 1);
    check(got[5] == arm + DLY + 5, "R3 first channel on time", got[5], arm + DLY + 5);

    // R4 loss of runnability clears the countdown
    wr(2'd2, 3'd3, EN);
    @(negedge clk); req = 7'b0001000;
    clear_got(); observe(5, 1);
    req = '0;
    observe(3, 1);
    @(negedge clk); c0 = cyc; req = 7'b0001000; arm = c0 + 1;
    observe(25, 1);
    check(got[3] == arm + DLY + 3, "R4 fresh delay after clear", got[3], arm + DLY + 3);

    // R9 control write goes through the countdown
    @(negedge clk); req = 7'b0010000;
    @(negedge clk);
    c0 = cyc;
    wr_en = 1'b1; reg_sel = 2'd2; reg_chan = 3'd4; wr_data = EN;
    @(negedge clk); wr_en = 1'b0;
    clear_got();
    if (start[4]) got[4] = cyc;
    observe(25, 1);
    check(got[4] == c0 + 2 + DLY + 4, "R9 write start delayed", got[4], c0 + 2 + DLY + 4);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule